// File: doc/BRIEF.md
# Prioritizing Two-Output Interrupt Controller

This block gathers up to 128 level-sensitive interrupt request lines and reduces them to two active-low processor request outputs: a fast request and a normal request. Every line has its own programmable urgency, a routing bit that selects which of the two outputs it feeds, and a mask bit. Two priority sorters work in parallel, one per output. Each picks the most urgent pending, unmasked line among the lines routed to it.

Software programs the block through a plain 32-bit word-addressed register port. The port has a write strobe, a read strobe, an address and write data, and it returns read data one cycle after the read strobe. For each output, software can read back the winning line number, the winner's urgency and a flag that says whether anything is pending. Both sorter results are registered, so every output and readback word follows its inputs with exactly one clock of latency.

Top module: `irq_sort_ctrl`

## Requirements
- R1: After reset, both request outputs are high. Every line is masked. Every line's urgency word reads 0x3F with the routing bit clear. Both status words read 0.
- R2: A request is level-sensitive. A line counts as pending only while its input is high. When the last pending input of an output drops, that output returns high and its status word returns to 0.
- R3: A masked line never drives an output low and never appears in a status word. Mask words sit at word addresses 128..131. Bit j of word 128+k masks line 32k+j, and a bit value of 1 means masked. Changing a mask bit while the line is pending takes effect on the next cycle.
- R4: Bit 8 of a line's configuration word routes the line: 1 sends it to the fast output, 0 sends it to the normal output. Each output considers only the lines routed to it. Rewriting the routing bit of a pending line moves the request to the other output.
- R5: Among the competing lines of one output, the line with the numerically smallest urgency value in bits [5:0] of its configuration word wins (0 is the most urgent).
- R6: When competing lines of one output have equal urgency, the line with the lower index wins.
- R7: Both outputs are sorted independently and at the same time, so each output can report a different winner in the same cycle.
- R8: The status words are read-only. Word 132 belongs to the fast output and word 133 to the normal output. Each holds the winning line number in bits [6:0], its urgency in bits [13:8] and a valid flag in bit 31. All other bits are zero, and the whole word is zero when the output has no pending line.
- R9: A request output and its status word change exactly one clock edge after a change on an input line, a mask bit, a routing bit or an urgency value.
- R10: Configuration word n (for n from 0 to 127) reads back its urgency in bits [5:0] and its routing bit in bit 8, with all other bits zero. Reads of unmapped addresses return 0. Writes to unmapped addresses or to status words change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 128 | Level-sensitive request lines, high = pending |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, valid the cycle after re_i |
| fast_req_no | output | 1 | Fast request to the processor, active low |
| norm_req_no | output | 1 | Normal request to the processor, active low |

## Verification
The assertions take for granted that the request lines and the register port carry known values at every clock edge. They also assume the urgency field never extends into the routing bit position, and that the line count is a power of two and a multiple of 32. The bench changes request lines and strobes only on the falling edge. It uses only addresses inside the register map, apart from one deliberate unmapped access. It holds the urgency values and line indices it drives within the programmed field widths, so the comparisons the sorter properties rely on stay meaningful.

// File: rtl/irq_sort_pkg.sv
package irq_sort_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned MASK_WORD_W  = 32;
  localparam int unsigned STEER_BIT    = 8;
  localparam int unsigned ST_PRIO_LSB  = 8;
  localparam int unsigned ST_VALID_BIT = 31;
  localparam int unsigned CH_FAST      = 0;
  localparam int unsigned CH_NORM      = 1;
  localparam int unsigned NUM_CH       = 2;
endpackage

// File: rtl/irq_sort_regs.sv
module irq_sort_regs
  import irq_sort_pkg::*;
#(
  parameter int unsigned N  = 128,
  parameter int unsigned PW = 6,
  parameter int unsigned AW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [REG_W-1:0]        fast_stat_i,
  input  logic [REG_W-1:0]        norm_stat_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic [N-1:0][PW-1:0]    prio_o,
  output logic [N-1:0]            steer_o,
  output logic [N-1:0]            mask_o
);
  localparam int unsigned MW        = N / MASK_WORD_W;
  localparam int unsigned FAST_ADDR = N + MW;
  localparam int unsigned NORM_ADDR = N + MW + 1;

  logic [N-1:0][PW-1:0] prio_q;
  logic [N-1:0]         steer_q;
  logic [N-1:0]         mask_q;
  logic [REG_W-1:0]     rdata_q;
  logic [REG_W-1:0]     rd_mux;
  int                   a_int;

  assign a_int = int'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '1;
      steer_q <= '0;
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (we_i) begin
        for (int k = 0; k < int'(N); k++) begin
          if (a_int == k) begin
            prio_q[k]  <= wdata_i[PW-1:0];
            steer_q[k] <= wdata_i[STEER_BIT];
          end
        end
        for (int w = 0; w < int'(MW); w++) begin
          if (a_int == int'(N) + w) mask_q[w*MASK_WORD_W +: MASK_WORD_W] <= wdata_i;
        end
      end
      if (re_i) rdata_q <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (a_int == k) begin
        rd_mux[PW-1:0]     = prio_q[k];
        rd_mux[STEER_BIT]  = steer_q[k];
      end
    end
    for (int w = 0; w < int'(MW); w++) begin
      if (a_int == int'(N) + w) rd_mux = mask_q[w*MASK_WORD_W +: MASK_WORD_W];
    end
    if (a_int == int'(FAST_ADDR)) rd_mux = fast_stat_i;
    if (a_int == int'(NORM_ADDR)) rd_mux = norm_stat_i;
  end

  assign rdata_o = rdata_q;
  assign prio_o  = prio_q;
  assign steer_o = steer_q;
  assign mask_o  = mask_q;

  // mask word 0 write lands next cycle
  assert_mask_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a_int == int'(N)) |=> (mask_o[MASK_WORD_W-1:0] == $past(wdata_i)));

  // status word writes ignored: config line 0 untouched
  assert_stat_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a_int == int'(FAST_ADDR)) |=> $stable(prio_o[0]) && $stable(steer_o[0]));
endmodule

// File: rtl/irq_sort_tree.sv
module irq_sort_tree #(
  parameter int unsigned N  = 128,
  parameter int unsigned PW = 6,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 valid_o,
  output logic [IW-1:0]        idx_o,
  output logic [PW-1:0]        prio_o
);
  localparam int unsigned NODES = 2 * N - 1;

  typedef struct packed {
    logic          v;
    logic [PW-1:0] p;
    logic [IW-1:0] i;
  } cand_t;

  cand_t node [NODES];
  cand_t win_q;

  // leaves in index order, left subtree always holds lower indices
  for (genvar k = 0; k < int'(N); k++) begin : g_leaf
    assign node[N-1+k] = {req_i[k], prio_i[k], IW'(k)};
  end

  for (genvar n = 0; n < int'(N) - 1; n++) begin : g_node
    logic take_r;
    assign take_r  = node[2*n+2].v && (!node[2*n+1].v || (node[2*n+2].p < node[2*n+1].p));
    assign node[n] = take_r ? node[2*n+2] : node[2*n+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= node[0].v ? node[0] : '0;
  end

  assign valid_o = win_q.v;
  assign idx_o   = win_q.i;
  assign prio_o  = win_q.p;

  assert_winner_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    node[0].v |-> req_i[node[0].i]);

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> valid_o);

  assert_idle_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> !valid_o);

  for (genvar j = 0; j < int'(N); j++) begin : g_chk
    assert_no_better_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (node[0].v && req_i[j]) |-> (prio_i[j] >= node[0].p));
    assert_tie_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (node[0].v && req_i[j] && prio_i[j] == node[0].p) |-> (int'(node[0].i) <= j));
  end
endmodule

// File: rtl/irq_sort_ctrl.sv
module irq_sort_ctrl
  import irq_sort_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 128,
  parameter int unsigned PRIO_W  = 6,
  localparam int unsigned AW = $clog2(NUM_IRQ + NUM_IRQ / MASK_WORD_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               fast_req_no,
  output logic               norm_req_no
);
  localparam int unsigned IW = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic [NUM_IRQ-1:0]             steer;
  logic [NUM_IRQ-1:0]             mask;
  logic [NUM_IRQ-1:0]             pend;
  logic [NUM_CH-1:0][NUM_IRQ-1:0] ch_req;
  logic [NUM_CH-1:0]              win_v;
  logic [NUM_CH-1:0][IW-1:0]      win_i;
  logic [NUM_CH-1:0][PRIO_W-1:0]  win_p;
  logic [NUM_CH-1:0][REG_W-1:0]   stat;

  irq_sort_regs #(.N(NUM_IRQ), .PW(PRIO_W), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .re_i        (re_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .fast_stat_i (stat[CH_FAST]),
    .norm_stat_i (stat[CH_NORM]),
    .rdata_o     (rdata_o),
    .prio_o      (prio),
    .steer_o     (steer),
    .mask_o      (mask)
  );

  assign pend            = irq_i & ~mask;
  assign ch_req[CH_FAST] = pend & steer;
  assign ch_req[CH_NORM] = pend & ~steer;

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    irq_sort_tree #(.N(NUM_IRQ), .PW(PRIO_W)) u_tree (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (ch_req[c]),
      .prio_i  (prio),
      .valid_o (win_v[c]),
      .idx_o   (win_i[c]),
      .prio_o  (win_p[c])
    );
  end

  always_comb begin
    for (int c = 0; c < int'(NUM_CH); c++) begin
      stat[c]                             = '0;
      stat[c][ST_VALID_BIT]               = win_v[c];
      stat[c][ST_PRIO_LSB +: PRIO_W]      = win_p[c];
      stat[c][IW-1:0]                     = win_i[c];
    end
  end

  assign fast_req_no = ~win_v[CH_FAST];
  assign norm_req_no = ~win_v[CH_NORM];

  assert_fast_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_i & ~mask & steer)) |=> !fast_req_no);

  assert_norm_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_i & ~mask & ~steer)) |=> !norm_req_no);

  assert_masked_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(irq_i & ~mask)) |=> (fast_req_no && norm_req_no));
endmodule

// File: tb/irq_sort_ctrl_tb.sv
module irq_sort_ctrl_tb;
  localparam int N      = 128;
  localparam int AW     = 8;
  localparam int MW     = 4;
  localparam int FAST_A = N + MW;
  localparam int NORM_A = N + MW + 1;
  localparam int NV     = 8;

  typedef struct packed {
    logic [7:0] la; logic [7:0] pa; logic sa; logic ma;
    logic [7:0] lb; logic [7:0] pb; logic sb; logic mb;
    logic fv; logic [7:0] fid; logic [7:0] fp;
    logic nv; logic [7:0] nid; logic [7:0] np;
  } vec_t;

  // line, urgency, route(1=fast), masked ... expected fast / normal winners
  localparam vec_t VECS [NV] = '{
    '{8'd5,   8'd10, 1'b1, 1'b0, 8'd9,   8'd3,  1'b1, 1'b0, 1'b1, 8'd9,   8'd3,  1'b0, 8'd0,  8'd0},
    '{8'd5,   8'd7,  1'b0, 1'b0, 8'd9,   8'd7,  1'b0, 1'b0, 1'b0, 8'd0,   8'd0,  1'b1, 8'd5,  8'd7},
    '{8'd100, 8'd2,  1'b1, 1'b0, 8'd3,   8'd40, 1'b0, 1'b0, 1'b1, 8'd100, 8'd2,  1'b1, 8'd3,  8'd40},
    '{8'd20,  8'd1,  1'b1, 1'b1, 8'd21,  8'd50, 1'b1, 1'b0, 1'b1, 8'd21,  8'd50, 1'b0, 8'd0,  8'd0},
    '{8'd0,   8'd0,  1'b0, 1'b1, 8'd127, 8'd63, 1'b0, 1'b1, 1'b0, 8'd0,   8'd0,  1'b0, 8'd0,  8'd0},
    '{8'd127, 8'd0,  1'b1, 1'b0, 8'd0,   8'd0,  1'b1, 1'b0, 1'b1, 8'd0,   8'd0,  1'b0, 8'd0,  8'd0},
    '{8'd64,  8'd12, 1'b0, 1'b0, 8'd65,  8'd11, 1'b1, 1'b0, 1'b1, 8'd65,  8'd11, 1'b1, 8'd64, 8'd12},
    '{8'd31,  8'd5,  1'b0, 1'b0, 8'd32,  8'd4,  1'b0, 1'b0, 1'b0, 8'd0,   8'd0,  1'b1, 8'd32, 8'd4}
  };
  localparam string TAGS [NV] = '{"R5", "R6", "R7", "R3", "R3", "R6", "R4", "R5"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          fast_no;
  logic          norm_no;
  int            n_vec = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  irq_sort_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_i       (irq),
    .we_i        (we),
    .re_i        (re),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .fast_req_no (fast_no),
    .norm_req_no (norm_no)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(input logic v, input logic [7:0] id, input logic [7:0] p);
    return v ? ((32'd1 << 31) | (32'(p[5:0]) << 8) | 32'(id[6:0])) : 32'd0;
  endfunction

  // all tasks enter and leave on a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a); re = 1'b1;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0]  d;
    logic [N-1:0] m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fast out", 32'(fast_no), 32'd1);
    chk("R1 norm out", 32'(norm_no), 32'd1);
    rd(0, d);      chk("R1 cfg word 0", d, 32'h3F);
    rd(127, d);    chk("R1 cfg word 127", d, 32'h3F);
    rd(N, d);      chk("R1 mask word 0", d, 32'hFFFF_FFFF);
    rd(N + 3, d);  chk("R1 mask word 3", d, 32'hFFFF_FFFF);
    rd(FAST_A, d); chk("R1 fast status", d, 32'd0);
    rd(NORM_A, d); chk("R1 norm status", d, 32'd0);

    // R3 all lines raised while all masked
    irq = '1; step();
    chk("R3 masked fast", 32'(fast_no), 32'd1);
    chk("R3 masked norm", 32'(norm_no), 32'd1);
    irq = '0;

    for (int v = 0; v < NV; v++) begin
      irq = '0;
      for (int w = 0; w < MW; w++) wr(N + w, 32'hFFFF_FFFF);
      wr(int'(VECS[v].la), (32'(VECS[v].sa) << 8) | 32'(VECS[v].pa));
      wr(int'(VECS[v].lb), (32'(VECS[v].sb) << 8) | 32'(VECS[v].pb));
      m = '1;
      if (!VECS[v].ma) m[VECS[v].la] = 1'b0;
      if (!VECS[v].mb) m[VECS[v].lb] = 1'b0;
      for (int w = 0; w < MW; w++) wr(N + w, m[w*32 +: 32]);
      irq[VECS[v].la] = 1'b1;
      irq[VECS[v].lb] = 1'b1;
      step();
      chk({TAGS[v], " fast out"}, 32'(fast_no), 32'(!VECS[v].fv));
      chk({TAGS[v], " norm out"}, 32'(norm_no), 32'(!VECS[v].nv));
      rd(FAST_A, d);
      chk({TAGS[v], " R8 fast status"}, d, stat_word(VECS[v].fv, VECS[v].fid, VECS[v].fp));
      rd(NORM_A, d);
      chk({TAGS[v], " R8 norm status"}, d, stat_word(VECS[v].nv, VECS[v].nid, VECS[v].np));
    end

    // R9 latency and R2 level behaviour on line 40 (mask word 1 bit 8)
    irq = '0;
    for (int w = 0; w < MW; w++) wr(N + w, 32'hFFFF_FFFF);
    wr(40, 32'h0000_0102);
    wr(N + 1, ~(32'd1 << 8));
    irq[40] = 1'b1;
    #1 chk("R9 before edge", 32'(fast_no), 32'd1);
    step();
    chk("R9 one edge later", 32'(fast_no), 32'd0);
    irq[40] = 1'b0;
    step();
    chk("R2 drop releases", 32'(fast_no), 32'd1);
    rd(FAST_A, d); chk("R2 status cleared", d, 32'd0);

    // R4 live reroute of a pending line
    irq[40] = 1'b1;
    step();
    chk("R4 fast before reroute", 32'(fast_no), 32'd0);
    wr(40, 32'h0000_0002);
    chk("R9 reroute not yet seen", 32'(fast_no), 32'd0);
    step();
    chk("R4 fast released", 32'(fast_no), 32'd1);
    chk("R4 norm taken", 32'(norm_no), 32'd0);
    rd(NORM_A, d); chk("R4 norm status", d, 32'h8000_0228);

    // R10 readback width, unmapped access, status read-only
    wr(7, 32'hFFFF_FFFF);
    rd(7, d);      chk("R10 cfg readback", d, 32'h0000_013F);
    wr(N + 6, 32'hDEAD_BEEF);
    rd(N + 6, d);  chk("R10 unmapped read", d, 32'd0);
    wr(FAST_A, 32'h1234_5678);
    rd(FAST_A, d); chk("R8 status not writable", d, 32'd0);

    // R3 masking a pending line
    wr(N + 1, 32'hFFFF_FFFF);
    step();
    chk("R3 live mask", 32'(norm_no), 32'd1);
    rd(NORM_A, d); chk("R3 live mask status", d, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule